// File: doc/BRIEF.md
# Speculation-Tagged General Register File

This block is a general register file in which every entry carries, next to its 64 data bits, one poison bit. The poison bit marks a value whose producing load hit a fault that was deferred rather than trapped. The file has two read ports and one write port, and every port moves the poison bit together with the data. A small execute stage sits in front of the write port. It models an integer datapath that forwards poison from its sources to its result, a load path fed by a memory-response stand-in with a fault flag, and a speculation-check operation that turns a poisoned register into a one-cycle control redirect toward recovery code.

One operation is presented per cycle on the op inputs. The two read ports always look up the op's source A and source B addresses, and the values they return are also visible at the top ports. A write is staged for one cycle and then committed. During that staging cycle it is forwarded to any read of the same register, so dependent operations can issue back to back. Register 0 is hardwired to a clean zero. Fault delivery, the recovery code and a real memory system lie outside the block.

Top module: `spec_tag_regfile`

## Requirements
- R1: The file holds 128 registers (addresses 0 to 127), each with 64 data bits and one poison bit. Read port A returns data and poison for `op_srca`, and read port B does the same for `op_srcb`. The top address 127 is writable and readable like any other.
- R2: Register 0 always reads as data 0 with poison clear. Every write aimed at address 0 is dropped.
- R3: The integer ops are ADD (code 1, A+B), SUB (code 2, A-B) and XOR (code 3, A^B). Each writes its result to `op_dst`. The result's poison bit is the OR of the two source poison bits.
- R4: MOVI (code 4) writes `op_imm` to `op_dst` with poison clear, so a clean write wipes any earlier poison in that register.
- R5: A normal load (code 5) without a fault writes `mem_data` to the destination with poison clear. With `mem_fault` high it writes nothing, and `fault_exc` is high for exactly the one cycle after the op.
- R6: A speculative load (code 6) with `mem_fault` high writes data 0 with poison set and raises no `fault_exc`. Without a fault it writes `mem_data` with poison clear.
- R7: A check (code 7) on a poisoned `op_srca` raises `redirect` for exactly the cycle after the op, with `redirect_target` equal to that op's `op_imm`. A check on a clean register gives no redirect. A check writes no register.
- R8: An op's result appears on both read ports from the cycle after the op. An op issued in that cycle that reads the register receives the new data and poison.
- R9: Reset clears every register's data and poison and drives `redirect` and `fault_exc` low.
- R10: When `op_valid` is low, or when the code is NOP (code 0), no register changes and neither `redirect` nor `fault_exc` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 3 | Operation code (see requirements) |
| op_dst | input | 7 | Destination register |
| op_srca | input | 7 | Source A address, read port A |
| op_srcb | input | 7 | Source B address, read port B |
| op_imm | input | 64 | Immediate value, or recovery target for a check |
| mem_data | input | 64 | Load response data |
| mem_fault | input | 1 | Load response fault flag |
| rd_a_data | output | 64 | Read port A data |
| rd_a_tag | output | 1 | Read port A poison bit |
| rd_b_data | output | 64 | Read port B data |
| rd_b_tag | output | 1 | Read port B poison bit |
| redirect | output | 1 | One-cycle request to branch to recovery code |
| redirect_target | output | 64 | Recovery target that goes with `redirect` |
| fault_exc | output | 1 | One-cycle fault raised by a normal load |

## Verification
Poison forwarding is driven with three source patterns: both sources clean, poison on source A only, and poison on source B only. These show whether the result tag ORs both sources or follows just one of them. Loads are run in all four combinations of normal or speculative with faulting or clean. These separate the deferred write from the immediate fault and from the unchanged destination. Checks are issued on poisoned and on clean registers, including the top address, so a redirect that fires wrongly or carries the wrong target shows up. A dependent op issued in the cycle right after its producer checks the forwarding path against the committed array value.

// File: rtl/spec_tag_pkg.sv
package spec_tag_pkg;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_ADD  = 3'd1,
    OP_SUB  = 3'd2,
    OP_XOR  = 3'd3,
    OP_MOVI = 3'd4,
    OP_LD   = 3'd5,
    OP_LDS  = 3'd6,
    OP_CHK  = 3'd7
  } op_e;

endpackage

// File: rtl/spec_tag_exec.sv
module spec_tag_exec
  import spec_tag_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int AW     = 7
) (
  input  logic              op_valid,
  input  op_e               op_code,
  input  logic [AW-1:0]     op_dst,
  input  logic [DATA_W-1:0] op_imm,
  input  logic [DATA_W-1:0] mem_data,
  input  logic              mem_fault,
  input  logic [DATA_W-1:0] a_data,
  input  logic              a_tag,
  input  logic [DATA_W-1:0] b_data,
  input  logic              b_tag,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_tag,
  output logic              chk_fire,
  output logic              ld_fault
);

  logic wr_any;

  always_comb begin
    wr_any   = 1'b0;
    wr_data  = '0;
    wr_tag   = 1'b0;
    chk_fire = 1'b0;
    ld_fault = 1'b0;
    if (op_valid) begin
      unique case (op_code)
        OP_ADD: begin
          wr_any  = 1'b1;
          wr_data = a_data + b_data;
          wr_tag  = a_tag | b_tag;
        end
        OP_SUB: begin
          wr_any  = 1'b1;
          wr_data = a_data - b_data;
          wr_tag  = a_tag | b_tag;
        end
        OP_XOR: begin
          wr_any  = 1'b1;
          wr_data = a_data ^ b_data;
          wr_tag  = a_tag | b_tag;
        end
        OP_MOVI: begin
          wr_any  = 1'b1;
          wr_data = op_imm;
        end
        OP_LD: begin
          if (mem_fault) begin
            ld_fault = 1'b1;
          end else begin
            wr_any  = 1'b1;
            wr_data = mem_data;
          end
        end
        OP_LDS: begin
          wr_any  = 1'b1;
          wr_data = mem_fault ? '0 : mem_data;
          wr_tag  = mem_fault;
        end
        OP_CHK: begin
          chk_fire = a_tag;
        end
        default: begin
          wr_any = 1'b0;
        end
      endcase
    end
  end

  assign wr_addr = op_dst;
  assign wr_en   = wr_any && (op_dst != '0);

endmodule

// File: rtl/spec_tag_array.sv
module spec_tag_array #(
  parameter int DATA_W = 64,
  parameter int NREGS  = 128,
  parameter int NRD    = 2,
  localparam int AW    = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_tag,
  input  logic [AW-1:0]     rd_addr [NRD],
  output logic [DATA_W-1:0] rd_data [NRD],
  output logic              rd_tag  [NRD]
);

  logic              stg_v_q, stg_v_d;
  logic [AW-1:0]     stg_addr_q, stg_addr_d;
  logic [DATA_W-1:0] stg_data_q, stg_data_d;
  logic              stg_tag_q, stg_tag_d;

  logic [DATA_W-1:0] mem_d [1:NREGS-1];
  logic              mem_t [1:NREGS-1];

  // staging register: next state
  always_comb begin
    stg_v_d    = wr_en;
    stg_addr_d = wr_en ? wr_addr : stg_addr_q;
    stg_data_d = wr_en ? wr_data : stg_data_q;
    stg_tag_d  = wr_en ? wr_tag  : stg_tag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_v_q    <= 1'b0;
      stg_addr_q <= '0;
      stg_data_q <= '0;
      stg_tag_q  <= 1'b0;
    end else begin
      stg_v_q    <= stg_v_d;
      stg_addr_q <= stg_addr_d;
      stg_data_q <= stg_data_d;
      stg_tag_q  <= stg_tag_d;
    end
  end

  // storage entries; entry 0 is not built
  for (genvar e = 1; e < NREGS; e++) begin : g_entry
    logic ent_en;
    assign ent_en = stg_v_q && (stg_addr_q == AW'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_d[e] <= '0;
        mem_t[e] <= 1'b0;
      end else if (ent_en) begin
        mem_d[e] <= stg_data_q;
        mem_t[e] <= stg_tag_q;
      end
    end
  end

  // read ports with forwarding from the staged write
  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb begin
      if (rd_addr[p] == '0) begin
        rd_data[p] = '0;
        rd_tag[p]  = 1'b0;
      end else if (stg_v_q && (stg_addr_q == rd_addr[p])) begin
        rd_data[p] = stg_data_q;
        rd_tag[p]  = stg_tag_q;
      end else begin
        rd_data[p] = mem_d[rd_addr[p]];
        rd_tag[p]  = mem_t[rd_addr[p]];
      end
    end
  end

  AST_NO_ZERO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr != '0)); // R2

  AST_STAGE_COMMITS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (stg_v_q && stg_addr_q == $past(wr_addr) && stg_tag_q == $past(wr_tag))); // R8

endmodule

// File: rtl/spec_tag_ctrl.sv
module spec_tag_ctrl #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_fire,
  input  logic              ld_fault,
  input  logic [DATA_W-1:0] op_imm,
  output logic              redirect,
  output logic [DATA_W-1:0] redirect_target,
  output logic              fault_exc
);

  logic              redir_q, redir_d;
  logic [DATA_W-1:0] tgt_q, tgt_d;
  logic              flt_q, flt_d;

  always_comb begin
    redir_d = chk_fire;
    tgt_d   = chk_fire ? op_imm : tgt_q;
    flt_d   = ld_fault;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redir_q <= 1'b0;
      tgt_q   <= '0;
      flt_q   <= 1'b0;
    end else begin
      redir_q <= redir_d;
      tgt_q   <= tgt_d;
      flt_q   <= flt_d;
    end
  end

  assign redirect        = redir_q;
  assign redirect_target = tgt_q;
  assign fault_exc       = flt_q;

endmodule

// File: rtl/spec_tag_regfile.sv
module spec_tag_regfile
  import spec_tag_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int NREGS  = 128,
  localparam int AW    = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic [AW-1:0]     op_dst,
  input  logic [AW-1:0]     op_srca,
  input  logic [AW-1:0]     op_srcb,
  input  logic [DATA_W-1:0] op_imm,
  input  logic [DATA_W-1:0] mem_data,
  input  logic              mem_fault,
  output logic [DATA_W-1:0] rd_a_data,
  output logic              rd_a_tag,
  output logic [DATA_W-1:0] rd_b_data,
  output logic              rd_b_tag,
  output logic              redirect,
  output logic [DATA_W-1:0] redirect_target,
  output logic              fault_exc
);

  localparam int NRD = 2;

  logic [AW-1:0]     rd_addr [NRD];
  logic [DATA_W-1:0] rd_data [NRD];
  logic              rd_tag  [NRD];

  logic              x_wr_en;
  logic [AW-1:0]     x_wr_addr;
  logic [DATA_W-1:0] x_wr_data;
  logic              x_wr_tag;
  logic              x_chk_fire;
  logic              x_ld_fault;

  assign rd_addr[0] = op_srca;
  assign rd_addr[1] = op_srcb;
  assign rd_a_data  = rd_data[0];
  assign rd_a_tag   = rd_tag[0];
  assign rd_b_data  = rd_data[1];
  assign rd_b_tag   = rd_tag[1];

  spec_tag_array #(
    .DATA_W (DATA_W),
    .NREGS  (NREGS),
    .NRD    (NRD)
  ) i_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (x_wr_en),
    .wr_addr (x_wr_addr),
    .wr_data (x_wr_data),
    .wr_tag  (x_wr_tag),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .rd_tag  (rd_tag)
  );

  spec_tag_exec #(
    .DATA_W (DATA_W),
    .AW     (AW)
  ) i_exec (
    .op_valid  (op_valid),
    .op_code   (op_e'(op_code)),
    .op_dst    (op_dst),
    .op_imm    (op_imm),
    .mem_data  (mem_data),
    .mem_fault (mem_fault),
    .a_data    (rd_data[0]),
    .a_tag     (rd_tag[0]),
    .b_data    (rd_data[1]),
    .b_tag     (rd_tag[1]),
    .wr_en     (x_wr_en),
    .wr_addr   (x_wr_addr),
    .wr_data   (x_wr_data),
    .wr_tag    (x_wr_tag),
    .chk_fire  (x_chk_fire),
    .ld_fault  (x_ld_fault)
  );

  spec_tag_ctrl #(
    .DATA_W (DATA_W)
  ) i_ctrl (
    .clk             (clk),
    .rst_n           (rst_n),
    .chk_fire        (x_chk_fire),
    .ld_fault        (x_ld_fault),
    .op_imm          (op_imm),
    .redirect        (redirect),
    .redirect_target (redirect_target),
    .fault_exc       (fault_exc)
  );

  logic alu_op;
  assign alu_op = (op_code == OP_ADD) || (op_code == OP_SUB) || (op_code == OP_XOR);

  AST_ZERO_REG_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (op_srca == '0) |-> (rd_a_data == '0 && !rd_a_tag)); // R2

  AST_TAG_FORWARDED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(op_valid && alu_op && (rd_a_tag || rd_b_tag) && op_dst != '0)
     && op_srca == $past(op_dst)) |-> rd_a_tag); // R3

  AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_LD && mem_fault) |-> !x_wr_en); // R5

  AST_FAULT_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    fault_exc |-> $past(op_valid && op_code == OP_LD && mem_fault)); // R5

  AST_SPEC_FAULT_POISONS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_LDS && mem_fault && op_dst != '0) |-> (x_wr_en && x_wr_tag)); // R6

  AST_REDIRECT_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> $past(op_valid && op_code == OP_CHK && rd_a_tag)); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> (!x_wr_en && !x_chk_fire && !x_ld_fault)); // R10

endmodule

// File: tb/test_spec_tag_regfile.sv
`timescale 1ns/1ps
module test_spec_tag_regfile;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [2:0]  op_code;
  logic [6:0]  op_dst, op_srca, op_srcb;
  logic [63:0] op_imm, mem_data;
  logic        mem_fault;
  logic [63:0] rd_a_data, rd_b_data, redirect_target;
  logic        rd_a_tag, rd_b_tag, redirect, fault_exc;

  int n_checks = 0;
  int n_errors = 0;

  always #2 clk = ~clk;

  spec_tag_regfile i_spec_tag_regfile (
    .clk (clk), .rst_n (rst_n), .op_valid (op_valid), .op_code (op_code),
    .op_dst (op_dst), .op_srca (op_srca), .op_srcb (op_srcb), .op_imm (op_imm),
    .mem_data (mem_data), .mem_fault (mem_fault),
    .rd_a_data (rd_a_data), .rd_a_tag (rd_a_tag), .rd_b_data (rd_b_data),
    .rd_b_tag (rd_b_tag), .redirect (redirect), .redirect_target (redirect_target),
    .fault_exc (fault_exc)
  );

  localparam logic [2:0] C_NOP = 3'd0, C_ADD = 3'd1, C_SUB = 3'd2, C_XOR = 3'd3,
                         C_MOVI = 3'd4, C_LD = 3'd5, C_LDS = 3'd6, C_CHK = 3'd7;

  typedef struct packed {
    logic [2:0]  code;
    logic [6:0]  dst;
    logic [6:0]  sa;
    logic [6:0]  sb;
    logic [63:0] imm;
    logic [63:0] mdata;
    logic        mfault;
    logic [6:0]  obs;
    logic [63:0] exp_data;
    logic        exp_tag;
    logic        exp_redir;
    logic [63:0] exp_tgt;
    logic        exp_fault;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{C_MOVI, 7'd5,  7'd0,  7'd0,  64'd100,  64'd0,   1'b0, 7'd5,   64'd100, 1'b0, 1'b0, 64'd0,     1'b0, 4'd4},  // R4
    '{C_MOVI, 7'd6,  7'd0,  7'd0,  64'd23,   64'd0,   1'b0, 7'd6,   64'd23,  1'b0, 1'b0, 64'd0,     1'b0, 4'd4},  // R4
    '{C_ADD,  7'd7,  7'd5,  7'd6,  64'd0,    64'd0,   1'b0, 7'd7,   64'd123, 1'b0, 1'b0, 64'd0,     1'b0, 4'd3},  // R3 clean sources
    '{C_SUB,  7'd8,  7'd5,  7'd6,  64'd0,    64'd0,   1'b0, 7'd8,   64'd77,  1'b0, 1'b0, 64'd0,     1'b0, 4'd3},  // R3
    '{C_XOR,  7'd9,  7'd5,  7'd6,  64'd0,    64'd0,   1'b0, 7'd9,   64'd115, 1'b0, 1'b0, 64'd0,     1'b0, 4'd3},  // R3
    '{C_LD,   7'd10, 7'd0,  7'd0,  64'd0,    64'hDEADBEEF, 1'b0, 7'd10, 64'hDEADBEEF, 1'b0, 1'b0, 64'd0, 1'b0, 4'd5}, // R5 clean load
    '{C_LDS,  7'd11, 7'd0,  7'd0,  64'd0,    64'd55,  1'b1, 7'd11,  64'd0,   1'b1, 1'b0, 64'd0,     1'b0, 4'd6},  // R6 deferred fault
    '{C_ADD,  7'd12, 7'd11, 7'd5,  64'd0,    64'd0,   1'b0, 7'd12,  64'd100, 1'b1, 1'b0, 64'd0,     1'b0, 4'd3},  // R3 poison on A
    '{C_XOR,  7'd13, 7'd5,  7'd12, 64'd0,    64'd0,   1'b0, 7'd13,  64'd0,   1'b1, 1'b0, 64'd0,     1'b0, 4'd3},  // R3 poison on B
    '{C_CHK,  7'd0,  7'd12, 7'd0,  64'h4000, 64'd0,   1'b0, 7'd12,  64'd100, 1'b1, 1'b1, 64'h4000,  1'b0, 4'd7},  // R7 poisoned
    '{C_CHK,  7'd0,  7'd5,  7'd0,  64'h5000, 64'd0,   1'b0, 7'd5,   64'd100, 1'b0, 1'b0, 64'd0,     1'b0, 4'd7},  // R7 clean
    '{C_LD,   7'd5,  7'd0,  7'd0,  64'd0,    64'd9,   1'b1, 7'd5,   64'd100, 1'b0, 1'b0, 64'd0,     1'b1, 4'd5},  // R5 fault
    '{C_LDS,  7'd14, 7'd0,  7'd0,  64'd0,    64'd77,  1'b0, 7'd14,  64'd77,  1'b0, 1'b0, 64'd0,     1'b0, 4'd6},  // R6 clean
    '{C_MOVI, 7'd12, 7'd0,  7'd0,  64'd5,    64'd0,   1'b0, 7'd12,  64'd5,   1'b0, 1'b0, 64'd0,     1'b0, 4'd4},  // R4 clears poison
    '{C_MOVI, 7'd0,  7'd0,  7'd0,  64'd99,   64'd0,   1'b0, 7'd0,   64'd0,   1'b0, 1'b0, 64'd0,     1'b0, 4'd2},  // R2
    '{C_LDS,  7'd0,  7'd0,  7'd0,  64'd0,    64'd3,   1'b1, 7'd0,   64'd0,   1'b0, 1'b0, 64'd0,     1'b0, 4'd2},  // R2
    '{C_ADD,  7'd15, 7'd0,  7'd5,  64'd0,    64'd0,   1'b0, 7'd15,  64'd100, 1'b0, 1'b0, 64'd0,     1'b0, 4'd2},  // R2 zero source
    '{C_LDS,  7'd127,7'd0,  7'd0,  64'd0,    64'd1,   1'b1, 7'd127, 64'd0,   1'b1, 1'b0, 64'd0,     1'b0, 4'd1},  // R1 top entry
    '{C_CHK,  7'd0,  7'd127,7'd0,  64'h77,   64'd0,   1'b0, 7'd127, 64'd0,   1'b1, 1'b1, 64'h77,    1'b0, 4'd7},  // R7
    '{C_NOP,  7'd5,  7'd0,  7'd0,  64'd1,    64'd1,   1'b0, 7'd5,   64'd100, 1'b0, 1'b0, 64'd0,     1'b0, 4'd10}  // R10
  };

  task automatic check(input string what, input int r, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL R%0d %s: actual %h expected %h", r, what, act, exp);
    end
  endtask

  task automatic idle();
    op_valid = 1'b0; op_code = C_NOP; op_dst = '0; op_srca = '0; op_srcb = '0;
    op_imm = '0; mem_data = '0; mem_fault = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_errors++;
    $display("FAIL R0 watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    do_reset();
    // R9: reset state
    op_srca = 7'd127; op_srcb = 7'd42;
    #1;
    check("reset data A", 9, rd_a_data, 64'd0);
    check("reset tag A", 9, {63'd0, rd_a_tag}, 64'd0);
    check("reset tag B", 9, {63'd0, rd_b_tag}, 64'd0);
    check("reset redirect", 9, {63'd0, redirect}, 64'd0);
    check("reset fault", 9, {63'd0, fault_exc}, 64'd0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      op_valid = 1'b1; op_code = VECS[i].code; op_dst = VECS[i].dst;
      op_srca = VECS[i].sa; op_srcb = VECS[i].sb; op_imm = VECS[i].imm;
      mem_data = VECS[i].mdata; mem_fault = VECS[i].mfault;
      if (VECS[i].code == C_NOP) op_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      idle();
      op_srca = VECS[i].obs;
      #1;
      check($sformatf("vec %0d data", i), int'(VECS[i].req), rd_a_data, VECS[i].exp_data);
      check($sformatf("vec %0d tag", i), int'(VECS[i].req), {63'd0, rd_a_tag}, {63'd0, VECS[i].exp_tag});
      check($sformatf("vec %0d redirect", i), int'(VECS[i].req), {63'd0, redirect}, {63'd0, VECS[i].exp_redir});
      if (VECS[i].exp_redir)
        check($sformatf("vec %0d target", i), int'(VECS[i].req), redirect_target, VECS[i].exp_tgt);
      check($sformatf("vec %0d fault", i), int'(VECS[i].req), {63'd0, fault_exc}, {63'd0, VECS[i].exp_fault});
    end

    // R10: op_valid low with a MOVI code writes nothing
    @(negedge clk);
    op_valid = 1'b0; op_code = C_MOVI; op_dst = 7'd6; op_imm = 64'd999;
    @(posedge clk); @(negedge clk);
    idle(); op_srca = 7'd6; #1;
    check("invalid op no write", 10, rd_a_data, 64'd23);

    // R8: back-to-back dependency through forwarding, both read ports
    @(negedge clk);
    op_valid = 1'b1; op_code = C_MOVI; op_dst = 7'd20; op_imm = 64'd7;
    @(posedge clk); @(negedge clk);
    op_code = C_ADD; op_dst = 7'd21; op_srca = 7'd20; op_srcb = 7'd20; op_imm = '0;
    #1;
    check("forwarded read B", 8, rd_b_data, 64'd7);
    @(posedge clk); @(negedge clk);
    idle(); op_srca = 7'd21; op_srcb = 7'd20; #1;
    check("dependent result", 8, rd_a_data, 64'd14);
    check("committed read B", 8, rd_b_data, 64'd7);

    // R8: poison forwarded into a back-to-back check
    @(negedge clk);
    op_valid = 1'b1; op_code = C_LDS; op_dst = 7'd22; mem_fault = 1'b1;
    @(posedge clk); @(negedge clk);
    op_code = C_CHK; op_srca = 7'd22; op_dst = '0; mem_fault = 1'b0; op_imm = 64'hABC;
    @(posedge clk); @(negedge clk);
    idle(); #1;
    check("forwarded poison redirect", 8, {63'd0, redirect}, 64'd1);
    check("forwarded redirect target", 7, redirect_target, 64'hABC);
    @(posedge clk); @(negedge clk); #1;
    check("redirect single cycle", 7, {63'd0, redirect}, 64'd0);

    // R9: reset mid-run clears poison and data
    do_reset();
    op_srca = 7'd127; op_srcb = 7'd10; #1;
    check("reset clears poison", 9, {63'd0, rd_a_tag}, 64'd0);
    check("reset clears data", 9, rd_b_data, 64'd0);

    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

endmodule